// File: doc/BRIEF.md
# External Bus Hold Handshake Controller

This block lets an outside master borrow a shared external memory bus. The outside master pulls an active-low hold request, which may change at any time relative to the local clock. The controller passes it through a flop synchronizer and lets any memory transaction already in progress finish. It then switches off the bus output drivers and, only after that, pulls an active-low hold acknowledge. When the request goes away, the controller drives the bus again and then releases the acknowledge. A configuration input can postpone the grant for as long as it stays set.

The controller is a five-state machine. OWN means the local side drives the bus. DRAIN means a request was seen and the controller waits for a minimum delay, for the busy input to drop and for the disable bit to clear. TRISTATE means the drivers are off and the acknowledge is not yet given. GRANTED means the acknowledge is low. RELEASE means the drivers are back on and the acknowledge is still low.

The transitions are these:
- OWN to DRAIN when the request is seen.
- DRAIN to OWN when the request is withdrawn.
- DRAIN to TRISTATE when the delay has run out, busy is low and disable is low.
- TRISTATE to OWN when the request is withdrawn.
- TRISTATE to GRANTED when the gap counter has run out and busy is low.
- GRANTED to RELEASE when the request is withdrawn.
- RELEASE to OWN when the release counter has run out.

Three parameters set the fixed delays: DRAIN_CYC, ACK_GAP and REL_CYC.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While reset is held, and right after it, `hold_ack_n` is 1 and `bus_oe` is 1, whatever `hold_req_n` does.
- R2: A request that goes low just after clock edge 0 reaches the state machine through two synchronizer flops. The machine enters DRAIN at edge 3. With busy and disable low, `bus_oe` falls at edge 3+DRAIN_CYC, which is 4 edges with DRAIN_CYC=1.
- R3: `bus_oe` stays 1 while `xfer_busy` is sampled high. It falls at the first edge, no earlier than edge 3+DRAIN_CYC, at which `xfer_busy` is sampled low.
- R4: While `hold_disable` is sampled 1, the bus is never released and the acknowledge is never given. When it clears, `bus_oe` falls at the next edge at which it is sampled 0.
- R5: `hold_ack_n` falls exactly ACK_GAP edges after `bus_oe` falls, and only while `bus_oe` is 0.
- R6: `hold_ack_n` never falls at an edge where `xfer_busy` was sampled high.
- R7: A request that goes high just after edge 0 makes `bus_oe` return to 1 at edge 3. It makes `hold_ack_n` return to 1 at edge 3+REL_CYC. The bus is therefore driven before the acknowledge is released.
- R8: If the request is withdrawn in DRAIN or TRISTATE, the machine returns to OWN. `hold_ack_n` never falls, and `bus_oe` is 1 from the edge of the return onward.
- R9: While GRANTED and the request stays low, `hold_ack_n` stays 0 and `bus_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | Asynchronous active-low bus request from the outside master |
| xfer_busy | input | 1 | High while the memory controller has a transaction in flight |
| hold_disable | input | 1 | When 1, the grant is held off |
| bus_oe | output | 1 | 1 enables the local bus drivers, 0 puts the bus in high impedance |
| hold_ack_n | output | 1 | Active-low acknowledge to the outside master |

## Verification
The bench runs full grant and release handshakes in a sweep over busy-pulse lengths. Short pulses check that the fixed minimum delay sets the tri-state edge. Longer pulses check that the end of busy sets it. A second sweep holds the disable bit for several lengths, alone and together with busy, so that each cause of delay is kept apart. Withdrawn requests are timed to land in DRAIN and in TRISTATE. These runs tell an early return to OWN apart from a late release after an acknowledge that should never have been given.

// File: rtl/hold_pkg.sv
package hold_pkg;
    typedef enum logic [2:0] {
        ST_OWN,
        ST_DRAIN,
        ST_TRISTATE,
        ST_GRANTED,
        ST_RELEASE
    } hold_state_t;
endpackage

// File: rtl/hold_sync.sv
// Multi-stage synchronizer for the asynchronous request pin.
module hold_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/hold_delay_cnt.sv
// Load-and-count-down timer; done while the count is zero.
module hold_delay_cnt #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import hold_pkg::*;
#(
    parameter int DRAIN_CYC = 1,
    parameter int ACK_GAP   = 1,
    parameter int REL_CYC   = 1,
    parameter int CW        = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_act,
    input  logic          busy,
    input  logic          hold_off,
    input  logic          cnt_done,
    output logic          cnt_load,
    output logic [CW-1:0] cnt_val,
    output logic          bus_oe,
    output logic          ack_n
);
    localparam logic [CW-1:0] DRAIN_LD = CW'(DRAIN_CYC - 1);
    localparam logic [CW-1:0] GAP_LD   = CW'(ACK_GAP - 1);
    localparam logic [CW-1:0] REL_LD   = CW'(REL_CYC - 1);

    hold_state_t state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OWN;
        else        state <= state_nx;
    end

    // Transitions and counter loads
    always_comb begin
        state_nx = state;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state)
            ST_OWN: begin
                if (req_act) begin
                    state_nx = ST_DRAIN;
                    cnt_load = 1'b1;
                    cnt_val  = DRAIN_LD;
                end
            end
            ST_DRAIN: begin
                if (!req_act) begin
                    state_nx = ST_OWN;
                end else if (cnt_done && !busy && !hold_off) begin
                    state_nx = ST_TRISTATE;
                    cnt_load = 1'b1;
                    cnt_val  = GAP_LD;
                end
            end
            ST_TRISTATE: begin
                if (!req_act)              state_nx = ST_OWN;
                else if (cnt_done && !busy) state_nx = ST_GRANTED;
            end
            ST_GRANTED: begin
                if (!req_act) begin
                    state_nx = ST_RELEASE;
                    cnt_load = 1'b1;
                    cnt_val  = REL_LD;
                end
            end
            ST_RELEASE: begin
                if (cnt_done) state_nx = ST_OWN;
            end
            default: state_nx = ST_OWN;
        endcase
    end

    // Output decode
    always_comb begin
        bus_oe = 1'b1;
        ack_n  = 1'b1;
        unique case (state)
            ST_OWN:      begin bus_oe = 1'b1; ack_n = 1'b1; end
            ST_DRAIN:    begin bus_oe = 1'b1; ack_n = 1'b1; end
            ST_TRISTATE: begin bus_oe = 1'b0; ack_n = 1'b1; end
            ST_GRANTED:  begin bus_oe = 1'b0; ack_n = 1'b0; end
            ST_RELEASE:  begin bus_oe = 1'b1; ack_n = 1'b0; end
            default:     begin bus_oe = 1'b1; ack_n = 1'b1; end
        endcase
    end
endmodule

// File: rtl/bus_hold_ctrl.sv
// Delays: DRAIN_CYC >= 1, ACK_GAP in 1..2, REL_CYC in 1..4.
module bus_hold_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int DRAIN_CYC   = 1,
    parameter int ACK_GAP     = 1,
    parameter int REL_CYC     = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req_n,
    input  logic xfer_busy,
    input  logic hold_disable,
    output logic bus_oe,
    output logic hold_ack_n
);
    localparam int MAX_AB = (DRAIN_CYC > ACK_GAP) ? DRAIN_CYC : ACK_GAP;
    localparam int MAXC   = (MAX_AB > REL_CYC) ? MAX_AB : REL_CYC;
    localparam int CW     = (MAXC < 2) ? 1 : $clog2(MAXC);

    logic          req_sync_n;
    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          cnt_done;

    hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (hold_req_n),
        .dout  (req_sync_n)
    );

    hold_delay_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    hold_fsm #(
        .DRAIN_CYC (DRAIN_CYC),
        .ACK_GAP   (ACK_GAP),
        .REL_CYC   (REL_CYC),
        .CW        (CW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_act  (!req_sync_n),
        .busy     (xfer_busy),
        .hold_off (hold_disable),
        .cnt_done (cnt_done),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .bus_oe   (bus_oe),
        .ack_n    (hold_ack_n)
    );
endmodule

// File: rtl/bus_hold_chk.sv
module bus_hold_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_busy,
    input logic hold_disable,
    input logic bus_oe,
    input logic hold_ack_n
);
    // R1: idle outputs while in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (hold_ack_n && bus_oe)
                else $error("R1 outputs not idle in reset");
        end
    end

    // R5: acknowledge falls only after the drivers are already off
    a_r5_tristate_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_n) |-> (!bus_oe && !$past(bus_oe)))
        else $error("R5 ack fell while bus driven");

    // R6: no grant at an edge with busy sampled high
    a_r6_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_n) |-> !$past(xfer_busy))
        else $error("R6 ack fell during busy");

    // R3: drivers not released at an edge with busy sampled high
    a_r3_drain_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> !$past(xfer_busy))
        else $error("R3 bus released during busy");

    // R4: drivers not released while disable is sampled set
    a_r4_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> !$past(hold_disable))
        else $error("R4 bus released while disabled");

    // R7: bus driven at least one cycle before ack is released
    a_r7_drive_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack_n) |-> (bus_oe && $past(bus_oe)))
        else $error("R7 ack released before bus driven");
endmodule

bind bus_hold_ctrl bus_hold_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_busy    (xfer_busy),
    .hold_disable (hold_disable),
    .bus_oe       (bus_oe),
    .hold_ack_n   (hold_ack_n)
);

// File: tb/tb_bus_hold_ctrl.sv
`timescale 1ns/1ps
module tb_bus_hold_ctrl;
    localparam int D = 2;
    localparam int G = 2;
    localparam int R = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req_n = 1'b0;
    logic xfer_busy = 1'b0;
    logic hold_disable = 1'b0;
    logic bus_oe;
    logic hold_ack_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_hold_ctrl #(.SYNC_STAGES(2), .DRAIN_CYC(D), .ACK_GAP(G), .REL_CYC(R)) dut (
        .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .xfer_busy(xfer_busy),
        .hold_disable(hold_disable), .bus_oe(bus_oe), .hold_ack_n(hold_ack_n)
    );

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Release: request high after edge 0; oe back at edge 3 (R7), ack at 3+R.
    task automatic run_release();
        hold_req_n = 1'b1;
        for (int n = 1; n <= 3 + R + 2; n++) begin
            tick();
            check("R7", "bus_oe", bus_oe, (n >= 3));
            check("R7", "hold_ack_n", hold_ack_n, (n >= 3 + R));
        end
    endtask

    // Grant with busy high for edges 1..bl and disable high for edges 1..dl.
    task automatic run_grant(int bl, int dl);
        int e;
        e = 3 + D;
        if (bl + 1 > e) e = bl + 1;
        if (dl + 1 > e) e = dl + 1;
        hold_req_n   = 1'b0;
        xfer_busy    = (bl > 0);
        hold_disable = (dl > 0);
        for (int n = 1; n <= e + G + 3; n++) begin
            tick();
            if (n < e)
                check((dl + 1 == e && dl > 0) ? "R4" : ((bl + 1 == e && bl > 0) ? "R3" : "R2"),
                      "bus_oe", bus_oe, 1'b1);
            else
                check("R2", "bus_oe", bus_oe, 1'b0);
            // R5 gap; R6: busy already low before ack falls; R9 held while granted
            check((n >= e + G) ? "R9" : "R5", "hold_ack_n", hold_ack_n, !(n >= e + G));
            if (n == bl) xfer_busy = 1'b0;
            if (n == dl) hold_disable = 1'b0;
        end
        run_release();
    endtask

    // R8: withdraw during DRAIN while busy keeps it there
    task automatic run_abort_drain(int wd);
        hold_req_n = 1'b0;
        xfer_busy  = 1'b1;
        for (int n = 1; n <= 20; n++) begin
            tick();
            check("R8", "bus_oe", bus_oe, 1'b1);
            check("R8", "hold_ack_n", hold_ack_n, 1'b1);
            if (n == wd) hold_req_n = 1'b1;
        end
        xfer_busy = 1'b0;
        for (int n = 1; n <= 5; n++) begin
            tick();
            check("R8", "bus_oe after busy", bus_oe, 1'b1);
            check("R8", "hold_ack_n after busy", hold_ack_n, 1'b1);
        end
    endtask

    // R8: withdraw seen in TRISTATE (edge 3+D+1), before grant at 3+D+G
    task automatic run_abort_tri();
        int wd;
        wd = D + 1;
        hold_req_n = 1'b0;
        for (int n = 1; n <= 3 + D + G + 4; n++) begin
            tick();
            check("R8", "bus_oe", bus_oe, !(n == 3 + D));
            check("R8", "hold_ack_n", hold_ack_n, 1'b1);
            if (n == wd) hold_req_n = 1'b1;
        end
    endtask

    initial begin
        // R1: request low during reset has no effect
        repeat (3) tick();
        check("R1", "bus_oe in reset", bus_oe, 1'b1);
        check("R1", "hold_ack_n in reset", hold_ack_n, 1'b1);
        hold_req_n = 1'b1;
        tick();
        rst_n = 1'b1;
        repeat (3) begin
            tick();
            check("R1", "bus_oe after reset", bus_oe, 1'b1);
            check("R1", "hold_ack_n after reset", hold_ack_n, 1'b1);
        end

        for (int bl = 0; bl <= 12; bl++) begin
            run_grant(bl, 0);
            repeat (2) tick();
        end
        for (int dl = 1; dl <= 24; dl += 3) begin
            run_grant(0, dl);
            repeat (2) tick();
        end
        run_grant(6, 14);
        repeat (2) tick();
        run_grant(15, 8);
        repeat (2) tick();
        for (int wd = 1; wd <= 12; wd += 4) begin
            run_abort_drain(wd);
            repeat (2) tick();
        end
        run_abort_tri();
        repeat (2) tick();
        run_grant(0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule